// File: doc/BRIEF.md
# Three-Class Prioritised Interrupt Controller

This block gathers up to 32 interrupt request lines and gives each one a class. A line in the fast class drives a dedicated fast interrupt output. Every other enabled line is a normal request. A normal request can be bound to one of 16 vectored slots. Each slot names a source and carries a vector address, and a lower slot index wins over a higher one. A normal request that no enabled slot claims is non-vectored and uses a single programmable default address. Fast requests always outrank normal ones, vectored slots outrank non-vectored requests, and all normal requests merge onto one IRQ output.

Software controls the block through a simple word-addressed register port. Reads are combinational in the cycle the read strobe is high, writes take effect at the clock edge, and the two strobes are never raised in the same cycle. When software reads the vector register, the winning slot index is latched as a priority hold. That slot, every lower-priority slot and all non-vectored requests then stop driving IRQ until software writes the end-of-interrupt register, while higher-priority slots can still interrupt. Request lines pass through one register stage before they reach any status or output. Class, enable and slot settings may be changed at any time and apply from the next cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable mask, class mask, slot controls, slot addresses and default address read 0, no hold is latched, and both fiq_o and irq_o are low.
- R2: Register word 0 returns the request lines as registered one clock after the input.
- R3: Word 3 returns lines that are requested, enabled (word 1 bit set) and fast (word 2 bit set), and fiq_o is high exactly when that set is non-empty.
- R4: Word 4 returns lines that are requested, enabled and not fast.
- R5: A fast-class line never activates a vectored slot and never drives irq_o, even when a slot names it.
- R6: Slot s is active when its control word (16+s, source in bits 4:0, enable in bit 8) is enabled and its source is in the word-4 set. A read of word 5 returns the address word (32+s) of the lowest-indexed active, unheld slot.
- R7: When no slot is eligible, a read of word 5 returns the default address (word 6).
- R8: Without a hold, irq_o is high when any slot is active or a word-4 line is claimed by no enabled slot.
- R9: A word-5 read that returns slot k holds slots k and above and all non-vectored lines off irq_o, while slots below k still raise it. A read that returns the default address with no hold latched holds all non-vectored lines.
- R10: Any write to word 5 clears the hold from the next cycle.
- R11: Rewriting a slot's source or enable, or a line's class, changes the vector and outputs from the next cycle.
- R12: A line whose enable bit is 0 appears in neither word 3 nor word 4 and drives neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 32 | Interrupt request lines, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (vector read side effect) |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| fiq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |

## Verification
The key coincidence is a vector read in the same cycle that a line of a higher-priority slot rises. The bench provokes it by driving the new request and the read strobe on the same clock edge. The read must return the older winner and latch its index as the hold. The newly pending slot sits below the hold level, so irq_o must stay high, and the next read must return that slot's address. A second coincidence pairs fast and normal lines in the same request pattern, and the bench judges fiq_o and irq_o each against its own class.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int REG_AW = 6;

  localparam logic [REG_AW-1:0] OFF_RAW   = 6'd0;
  localparam logic [REG_AW-1:0] OFF_EN    = 6'd1;
  localparam logic [REG_AW-1:0] OFF_FAST  = 6'd2;
  localparam logic [REG_AW-1:0] OFF_FSTAT = 6'd3;
  localparam logic [REG_AW-1:0] OFF_ISTAT = 6'd4;
  localparam logic [REG_AW-1:0] OFF_VECT  = 6'd5;
  localparam logic [REG_AW-1:0] OFF_DFLT  = 6'd6;

  localparam logic [1:0] RGN_SLOT_CTRL = 2'b01;
  localparam logic [1:0] RGN_SLOT_ADDR = 2'b10;

  localparam int SLOT_EN_BIT = 8;
  localparam int HOLD_W      = 5;

  typedef struct packed {
    logic              valid;
    logic [HOLD_W-1:0] lvl;
  } hold_t;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32,
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr,
  input  logic [REG_AW-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wdata,
  output logic [NUM_SRC-1:0]                  en_q,
  output logic [NUM_SRC-1:0]                  fast_q,
  output logic [DATA_W-1:0]                   dflt_q,
  output logic [NUM_SLOTS-1:0]                slot_en,
  output logic [NUM_SLOTS-1:0][SRC_W-1:0]     slot_src,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]    slot_addr,
  output logic                                eoi
);
  assign eoi = wr && (addr == OFF_VECT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      fast_q <= '0;
      dflt_q <= '0;
    end else if (wr) begin
      if (addr == OFF_EN)   en_q   <= wdata[NUM_SRC-1:0];
      if (addr == OFF_FAST) fast_q <= wdata[NUM_SRC-1:0];
      if (addr == OFF_DFLT) dflt_q <= wdata;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [3:0] SIDX = 4'(s);
    logic sel_ctrl, sel_addr;
    assign sel_ctrl = wr && (addr[5:4] == RGN_SLOT_CTRL) && (addr[3:0] == SIDX);
    assign sel_addr = wr && (addr[5:4] == RGN_SLOT_ADDR) && (addr[3:0] == SIDX);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_en[s]   <= 1'b0;
        slot_src[s]  <= '0;
        slot_addr[s] <= '0;
      end else begin
        if (sel_ctrl) begin
          slot_en[s]  <= wdata[SLOT_EN_BIT];
          slot_src[s] <= wdata[SRC_W-1:0];
        end
        if (sel_addr) slot_addr[s] <= wdata;
      end
    end
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int IW       = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SRC-1:0]              norm_pend,
  input  logic [NUM_SLOTS-1:0]            slot_en,
  input  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src,
  input  hold_t                           hold,
  output logic [NUM_SLOTS-1:0]            slot_act,
  output logic                            win_valid,
  output logic [IW-1:0]                   win_idx,
  output logic [NUM_SRC-1:0]              claimed
);
  logic [NUM_SLOTS-1:0] elig;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_match
    localparam logic [HOLD_W-1:0] SLVL = HOLD_W'(s);
    assign slot_act[s] = slot_en[s] && norm_pend[slot_src[s]];
    assign elig[s]     = slot_act[s] && (!hold.valid || (SLVL < hold.lvl));
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (elig[s]) begin
        win_valid = 1'b1;
        win_idx   = IW'(s);
      end
    end
  end

  always_comb begin
    claimed = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_en[s]) claimed[slot_src[s]] = 1'b1;
    end
  end
endmodule

// File: rtl/prio_irq_hold.sv
module prio_irq_hold
  import prio_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IW       = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vect_rd,
  input  logic          eoi,
  input  logic          win_valid,
  input  logic [IW-1:0] win_idx,
  output hold_t         hold
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (eoi) begin
      hold <= '0;
    end else if (vect_rd) begin
      if (win_valid) begin
        hold.valid <= 1'b1;
        hold.lvl   <= HOLD_W'(win_idx);
      end else if (!hold.valid) begin
        hold.valid <= 1'b1;
        hold.lvl   <= HOLD_W'(NUM_SLOTS);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       irq_src,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int IW    = $clog2(NUM_SLOTS);

  logic [NUM_SRC-1:0]              req_q;
  logic [NUM_SRC-1:0]              en_q, fast_q;
  logic [DATA_W-1:0]               dflt_q;
  logic [NUM_SLOTS-1:0]            slot_en;
  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_addr;
  logic                            eoi, vect_rd;
  logic [NUM_SRC-1:0]              fast_pend, norm_pend, claimed, nonvec;
  logic [NUM_SLOTS-1:0]            slot_act;
  logic                            win_valid;
  logic [IW-1:0]                   win_idx;
  hold_t                           hold;
  logic [DATA_W-1:0]               vect_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= irq_src[NUM_SRC-1:0];
  end

  prio_irq_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .en_q      (en_q),
    .fast_q    (fast_q),
    .dflt_q    (dflt_q),
    .slot_en   (slot_en),
    .slot_src  (slot_src),
    .slot_addr (slot_addr),
    .eoi       (eoi)
  );

  assign fast_pend = req_q & en_q & fast_q;
  assign norm_pend = req_q & en_q & ~fast_q;

  prio_irq_arb #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS)) u_arb (
    .norm_pend (norm_pend),
    .slot_en   (slot_en),
    .slot_src  (slot_src),
    .hold      (hold),
    .slot_act  (slot_act),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .claimed   (claimed)
  );

  assign vect_rd = reg_rd && (reg_addr == OFF_VECT);

  prio_irq_hold #(.NUM_SLOTS(NUM_SLOTS)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .vect_rd   (vect_rd),
    .eoi       (eoi),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .hold      (hold)
  );

  assign nonvec    = norm_pend & ~claimed;
  assign vect_addr = win_valid ? slot_addr[win_idx] : dflt_q;
  assign fiq_o     = |fast_pend;
  assign irq_o     = win_valid || (!hold.valid && |nonvec);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr[5:4])
      RGN_SLOT_CTRL: begin
        if (32'(reg_addr[3:0]) < NUM_SLOTS) begin
          reg_rdata[SRC_W-1:0]  = slot_src[reg_addr[IW-1:0]];
          reg_rdata[SLOT_EN_BIT] = slot_en[reg_addr[IW-1:0]];
        end
      end
      RGN_SLOT_ADDR: begin
        if (32'(reg_addr[3:0]) < NUM_SLOTS) reg_rdata = slot_addr[reg_addr[IW-1:0]];
      end
      2'b00: begin
        case (reg_addr)
          OFF_RAW:   reg_rdata[NUM_SRC-1:0] = req_q;
          OFF_EN:    reg_rdata[NUM_SRC-1:0] = en_q;
          OFF_FAST:  reg_rdata[NUM_SRC-1:0] = fast_q;
          OFF_FSTAT: reg_rdata[NUM_SRC-1:0] = fast_pend;
          OFF_ISTAT: reg_rdata[NUM_SRC-1:0] = norm_pend;
          OFF_VECT:  reg_rdata = vect_addr;
          OFF_DFLT:  reg_rdata = dflt_q;
          default:   reg_rdata = '0;
        endcase
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  localparam int IW       = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fiq_o,
  input logic                 irq_o,
  input logic                 reg_wr,
  input logic                 reg_rd,
  input logic [5:0]           reg_addr,
  input logic [NUM_SRC-1:0]   req_q,
  input logic [NUM_SRC-1:0]   en_q,
  input logic [NUM_SRC-1:0]   fast_q,
  input logic [NUM_SLOTS-1:0] slot_en,
  input logic                 win_valid,
  input logic [IW-1:0]        win_idx,
  input hold_t                hold
);
  // R1: outputs quiet right after a reset cycle
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!fiq_o && !irq_o));

  // R3: fast output only with an enabled fast line present
  assert_fiq_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> |(req_q & en_q & fast_q));

  // R5: normal output needs an enabled non-fast line
  assert_irq_not_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(req_q & en_q & ~fast_q));

  // R6: the winner is always an enabled slot
  assert_winner_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> slot_en[win_idx]);

  // R9: a vector read with a winner latches that index
  assert_hold_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == OFF_VECT && win_valid)
      |=> (hold.valid && hold.lvl == HOLD_W'($past(win_idx))));

  // R9: under a hold only strictly higher slots may win
  assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold.valid && win_valid) |-> (HOLD_W'(win_idx) < hold.lvl));

  // R10: end-of-interrupt write clears the hold
  assert_eoi_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_VECT) |=> !hold.valid);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fiq_o     (fiq_o),
  .irq_o     (irq_o),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .req_q     (req_q),
  .en_q      (en_q),
  .fast_q    (fast_q),
  .slot_en   (slot_en),
  .win_valid (win_valid),
  .win_idx   (win_idx),
  .hold      (hold)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam logic [5:0] A_RAW = 6'd0, A_EN = 6'd1, A_FAST = 6'd2, A_FSTAT = 6'd3,
                         A_ISTAT = 6'd4, A_VECT = 6'd5, A_DFLT = 6'd6;
  localparam logic [31:0] DFLT = 32'hDEAD_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fiq_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic drive_req(input logic [31:0] v);
    @(negedge clk); irq_src = v;
    @(posedge clk); #1;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  function automatic logic [4:0] src_of(input int k);
    return 5'(31 - k);
  endfunction

  function automatic logic [31:0] slot_va(input int k);
    return 32'h8000_0000 + 32'(k) * 32'd16;
  endfunction

  function automatic logic [31:0] req_of_mask(input logic [15:0] m);
    logic [31:0] r = '0;
    for (int k = 0; k < 16; k++) if (m[k]) r[src_of(k)] = 1'b1;
    return r;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, en, fs, rq, m32;
    logic [15:0] m;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 fiq_o", 32'(fiq_o), 0);
    chk("R1 irq_o", 32'(irq_o), 0);
    rd_reg(A_EN, d);    chk("R1 enable", d, 0);
    rd_reg(A_FAST, d);  chk("R1 class", d, 0);
    rd_reg(6'h10, d);   chk("R1 slot0 ctrl", d, 0);
    rd_reg(6'h2F, d);   chk("R1 slot15 addr", d, 0);
    rd_reg(A_VECT, d);  chk("R1 R7 vector default", d, 0);
    wr_reg(A_VECT, 0);

    // R2 raw status, one line at a time
    for (int s = 0; s < 32; s++) begin
      drive_req(32'h1 << s);
      rd_reg(A_RAW, d);
      chk("R2 raw", d, 32'h1 << s);
    end

    // R3 R4 R8 R12 class and enable sweep, no slots enabled
    for (int i = 0; i < 20; i++) begin
      en = 32'(i) * 32'h9E37_79B1;
      fs = (32'(i) * 32'h7F4A_7C15) ^ 32'h0F0F_0F0F;
      rq = ~(32'(i) * 32'h3C6E_F372);
      wr_reg(A_EN, en);
      wr_reg(A_FAST, fs);
      drive_req(rq);
      settle();
      chk("R3 R12 fiq_o", 32'(fiq_o), 32'(|(rq & en & fs)));
      chk("R8 R12 irq_o nonvectored", 32'(irq_o), 32'(|(rq & en & ~fs)));
      rd_reg(A_FSTAT, d); chk("R3 R12 fast status", d, rq & en & fs);
      rd_reg(A_ISTAT, d); chk("R4 R12 normal status", d, rq & en & ~fs);
    end

    // slot setup: slot k serves line 31-k
    drive_req(0);
    wr_reg(A_EN, 32'hFFFF_FFFF);
    wr_reg(A_FAST, 0);
    wr_reg(A_DFLT, DFLT);
    for (int k = 0; k < 16; k++) begin
      wr_reg(6'h10 + 6'(k), 32'h100 | 32'(src_of(k)));
      wr_reg(6'h20 + 6'(k), slot_va(k));
    end
    rd_reg(6'h13, d); chk("R6 slot3 ctrl readback", d, 32'h100 | 32'd28);

    // R6 R7 R8 priority sweep
    for (int i = 0; i < 48; i++) begin
      m = 16'((32'(i) * 32'd40503) ^ (32'(i) << 7));
      if (i == 0) m = '0;
      drive_req(req_of_mask(m));
      settle();
      chk("R8 irq_o vectored", 32'(irq_o), 32'(m != 0));
      m32 = DFLT;
      for (int k = 15; k >= 0; k--) if (m[k]) m32 = slot_va(k);
      rd_reg(A_VECT, d);
      chk("R6 R7 vector", d, m32);
      wr_reg(A_VECT, 0);
    end

    // R9 R10 hold: slots 3 and 7 plus non-vectored line 0
    drive_req(req_of_mask(16'h0088) | 32'h1);
    rd_reg(A_VECT, d); chk("R9 first winner", d, slot_va(3));
    settle();
    chk("R9 held slots off irq_o", 32'(irq_o), 0);
    drive_req(req_of_mask(16'h008A) | 32'h1);
    settle();
    chk("R9 higher slot raises irq_o", 32'(irq_o), 1);
    rd_reg(A_VECT, d); chk("R9 higher slot vector", d, slot_va(1));
    wr_reg(A_VECT, 0);
    settle();
    chk("R10 irq_o after eoi", 32'(irq_o), 1);
    rd_reg(A_VECT, d); chk("R10 vector after eoi", d, slot_va(1));
    wr_reg(A_VECT, 0);

    // R9 R10 default read holds non-vectored lines
    drive_req(32'h1);
    rd_reg(A_VECT, d); chk("R7 default vector", d, DFLT);
    settle();
    chk("R9 nonvectored held", 32'(irq_o), 0);
    wr_reg(A_VECT, 0);
    settle();
    chk("R10 nonvectored released", 32'(irq_o), 1);

    // R9 coincidence: read while a higher slot's line rises
    drive_req(req_of_mask(16'h0020));
    @(negedge clk);
    irq_src = req_of_mask(16'h0024);
    reg_rd = 1'b1; reg_addr = A_VECT;
    #2 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
    chk("R9 read beside new request returns old winner", d, slot_va(5));
    settle();
    chk("R9 newer higher slot raises irq_o", 32'(irq_o), 1);
    rd_reg(A_VECT, d); chk("R9 newer higher slot vector", d, slot_va(2));
    wr_reg(A_VECT, 0);

    // R5 R11 fast reclass at run time
    drive_req(32'h1 << 27);
    settle();
    chk("R11 slot4 raises irq_o", 32'(irq_o), 1);
    wr_reg(A_FAST, 32'h1 << 27);
    settle();
    chk("R5 fast line off irq_o", 32'(irq_o), 0);
    chk("R5 fast line on fiq_o", 32'(fiq_o), 1);
    rd_reg(A_VECT, d); chk("R5 fast line has no slot", d, DFLT);
    wr_reg(A_VECT, 0);
    wr_reg(A_FAST, 0);

    // R11 rebind slot 4 to line 2, then disable it
    wr_reg(6'h14, 32'h100 | 32'd2);
    drive_req(32'h4);
    rd_reg(A_VECT, d); chk("R11 rebound slot4", d, slot_va(4));
    wr_reg(A_VECT, 0);
    wr_reg(6'h14, 32'd2);
    rd_reg(A_VECT, d); chk("R11 disabled slot4", d, DFLT);
    wr_reg(A_VECT, 0);
    settle();
    chk("R8 unclaimed line raises irq_o", 32'(irq_o), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule